// File: doc/BRIEF.md
# Packed Symbol Sliding Window Register

This block feeds an anti-diagonal sequence-alignment array with a window of N consecutive database symbols, all N presented in parallel on one wide bus. Each symbol is a 2-bit code for one of four nucleotide classes. The database sits in memory as 32-bit words that each carry sixteen symbols. The block unpacks that stream internally and hands the array one new symbol per step.

A sweep begins with a `start` pulse that captures the database length. The block then loads the first N symbols into the window on its own, one symbol per cycle, and raises `adv_ready`. From then on, each cycle in which `advance` is high while `adv_ready` is high moves the window one symbol toward position 0. The oldest symbol leaves the window and the next unread symbol enters at the top position N-1. Once the database runs out, the top is filled with code 0 and its valid bit is cleared, so padding is never mistaken for data. After length + N - 1 accepted advances the sweep ends and `done` is raised.

The memory port has a fixed read latency of one cycle. A word addressed while `mem_rd_en` is high must appear on `mem_rd_data` in the following cycle and is taken at the next rising edge. At most two words are held inside the block. A further word is requested only once a held word has been fully consumed.

Top module: `sym_window`

## Requirements
- R1: While reset is active and after it is released, `win_sym` and `win_vld` are all zero, and `done`, `adv_ready` and `mem_rd_en` are low.
- R2: Database symbol j is bits [2(j mod 16)+1 : 2(j mod 16)] of memory word j/16. Window position i is carried on `win_sym[2i+1:2i]`, and its valid flag is `win_vld[i]`.
- R3: After an accepted `start`, the window fills without any `advance`. When `adv_ready` first rises, position i holds database symbol i for every i.
- R4: Each accepted advance (`advance` and `adv_ready` both high at a rising edge) moves the symbol at each position i to position i-1 for i from 1 to N-1, drops the symbol at position 0, and writes the next unread database symbol into position N-1. After k accepted advances, position i therefore holds symbol k+i.
- R5: A position whose symbol index is at or beyond the database length holds code 0 with its valid flag cleared. Once the sweep is running, the valid flags always form a contiguous run starting at position 0.
- R6: From the first rise of `adv_ready` until `done`, `adv_ready` stays high in every cycle, so advances can be accepted back to back at one per cycle.
- R7: Memory words are read at consecutive addresses starting at 0. Each word is read exactly once, for a total of ceil(length/16) reads per sweep. No new read is issued while one is still outstanding.
- R8: `done` rises after exactly length + N - 1 accepted advances. In the same cycle `adv_ready` falls. `done` then holds until the next accepted `start`.
- R9: `advance` has no effect while `adv_ready` is low, both during the fill and after `done`.
- R10: `start` is ignored while a fill or a sweep is in progress.
- R11: `start` accepted while `done` is high begins a new sweep using the newly given length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a sweep; accepted when idle or done |
| db_len | input | LEN_W | Database length in symbols, captured at start |
| advance | input | 1 | Request to move the window by one symbol |
| adv_ready | output | 1 | Window filled and an advance can be taken |
| win_sym | output | 2*N | Window symbols, position i at bits [2i+1:2i] |
| win_vld | output | N | Valid flag per window position |
| done | output | 1 | Sweep finished after length + N - 1 advances |
| mem_rd_en | output | 1 | Memory read request |
| mem_rd_addr | output | LEN_W-3 | Word address of the read |
| mem_rd_data | input | 32 | Read data, one cycle after the request |

## Verification
The hardest case to reach from the ports is a word boundary in the middle of a run of back-to-back advances. In that cycle the held word is used up, the prefetched word takes its place, and a new read is issued, all while the window must not lose a cycle. A second hard case is the database ending partway through a word, so that padding begins at an odd symbol offset. The stimulus reaches both by holding `advance` high continuously for lengths of 37 and 32, which cross several word boundaries and end both mid-word and on a word edge. It also runs a length shorter than the window and a zero length, in which padding enters during the fill itself. Gapped advance patterns, together with `start` and `advance` pulses at the wrong times, confirm that idle cycles leave the window untouched.

// File: rtl/sww_pkg.sv
package sww_pkg;
  localparam int SYM_W     = 2;
  localparam int WORD_W    = 32;
  localparam int PER_WORD  = WORD_W / SYM_W;
  localparam int IDX_W     = $clog2(PER_WORD);

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FILL = 2'd1,
    ST_RUN  = 2'd2,
    ST_DONE = 2'd3
  } sweep_st_t;

  // Symbol k of a packed word sits at bits [2k+1:2k].
  function automatic logic [SYM_W-1:0] pick_sym(input logic [WORD_W-1:0] w,
                                                input logic [IDX_W-1:0] k);
    return w[{k, 1'b0} +: SYM_W];
  endfunction

  function automatic logic word_end(input logic [IDX_W-1:0] k);
    return k == IDX_W'(PER_WORD - 1);
  endfunction
endpackage

// File: rtl/sww_fetch.sv
module sww_fetch
  import sww_pkg::*;
#(
  parameter int LEN_W  = 20,
  parameter int ADDR_W = LEN_W - 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                restart,
  input  logic                active,
  input  logic                shift_req,
  input  logic [LEN_W-1:0]    len_q,
  input  logic [WORD_W-1:0]   mem_rd_data,
  output logic                mem_rd_en,
  output logic [ADDR_W-1:0]   mem_rd_addr,
  output logic [SYM_W-1:0]    sym_out,
  output logic                sym_real,
  output logic                sym_avail,
  output logic                rd_pend
);
  logic [WORD_W-1:0] cur_w, nxt_w, cur_w_n, nxt_w_n;
  logic              cur_f, nxt_f, cur_f_n, nxt_f_n;
  logic [IDX_W-1:0]  idx;
  logic [LEN_W-1:0]  taken;
  logic [ADDR_W-1:0] issued, nwords;
  logic [LEN_W:0]    len_round;
  logic              exhausted, take, last_take;

  assign len_round = {1'b0, len_q} + (LEN_W+1)'(PER_WORD - 1);
  assign nwords    = ADDR_W'(len_round >> IDX_W);
  assign exhausted = (taken == len_q);
  assign take      = shift_req && !exhausted;
  assign last_take = take && (word_end(idx) || (taken == len_q - 1'b1));

  assign mem_rd_en   = active && !rd_pend && (issued < nwords) && !(cur_f && nxt_f);
  assign mem_rd_addr = issued;

  assign sym_out   = exhausted ? '0 : pick_sym(cur_w, idx);
  assign sym_real  = !exhausted;
  assign sym_avail = exhausted || cur_f;

  always_comb begin
    cur_f_n = cur_f;
    nxt_f_n = nxt_f;
    cur_w_n = cur_w;
    nxt_w_n = nxt_w;
    if (last_take) begin
      cur_f_n = nxt_f;
      cur_w_n = nxt_w;
      nxt_f_n = 1'b0;
    end
    if (rd_pend) begin
      if (!cur_f_n) begin
        cur_f_n = 1'b1;
        cur_w_n = mem_rd_data;
      end else begin
        nxt_f_n = 1'b1;
        nxt_w_n = mem_rd_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      cur_w   <= '0;
      nxt_w   <= '0;
      cur_f   <= 1'b0;
      nxt_f   <= 1'b0;
      rd_pend <= 1'b0;
      idx     <= '0;
      taken   <= '0;
      issued  <= '0;
    end else begin
      cur_w   <= cur_w_n;
      nxt_w   <= nxt_w_n;
      cur_f   <= cur_f_n;
      nxt_f   <= nxt_f_n;
      rd_pend <= mem_rd_en;
      if (mem_rd_en) issued <= issued + 1'b1;
      if (take) begin
        taken <= taken + 1'b1;
        idx   <= last_take ? '0 : idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sww_shift.sv
module sww_shift
  import sww_pkg::*;
#(
  parameter int N = 256
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clear,
  input  logic                 shift,
  input  logic [SYM_W-1:0]     sym_in,
  input  logic                 vld_in,
  output logic [SYM_W*N-1:0]   win_sym,
  output logic [N-1:0]         win_vld
);
  logic [SYM_W-1:0] sym_q [N];
  logic             vld_q [N];

  for (genvar p = 0; p < N; p++) begin : g_pos
    logic [SYM_W-1:0] src_sym;
    logic             src_vld;
    if (p == N - 1) begin : g_top
      assign src_sym = sym_in;
      assign src_vld = vld_in;
    end else begin : g_mid
      assign src_sym = sym_q[p+1];
      assign src_vld = vld_q[p+1];
    end

    always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
        sym_q[p] <= '0;
        vld_q[p] <= 1'b0;
      end else if (shift) begin
        sym_q[p] <= src_sym;
        vld_q[p] <= src_vld;
      end
    end

    assign win_sym[p*SYM_W +: SYM_W] = sym_q[p];
    assign win_vld[p]                = vld_q[p];
  end
endmodule

// File: rtl/sww_ctrl.sv
module sww_ctrl
  import sww_pkg::*;
#(
  parameter int N     = 256,
  parameter int LEN_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] db_len,
  input  logic             advance,
  input  logic             sym_avail,
  output logic             start_acc,
  output logic             active,
  output logic             shift_fire,
  output logic             adv_ready,
  output logic             done,
  output logic             window_live,
  output logic [LEN_W-1:0] len_q
);
  localparam int FILL_W = $clog2(N) + 1;
  localparam int CNT_W  = LEN_W + 1;

  sweep_st_t         st;
  logic [FILL_W-1:0] fill_cnt;
  logic [CNT_W-1:0]  adv_cnt, target;
  logic              fill_fire, adv_fire;

  assign start_acc   = start && (st == ST_IDLE || st == ST_DONE);
  assign active      = (st == ST_FILL) || (st == ST_RUN);
  assign adv_ready   = (st == ST_RUN) && sym_avail;
  assign done        = (st == ST_DONE);
  assign window_live = (st == ST_RUN) || (st == ST_DONE);
  assign fill_fire   = (st == ST_FILL) && sym_avail;
  assign adv_fire    = adv_ready && advance;
  assign shift_fire  = fill_fire || adv_fire;
  assign target      = {1'b0, len_q} + CNT_W'(N - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      len_q    <= '0;
      fill_cnt <= '0;
      adv_cnt  <= '0;
    end else if (start_acc) begin
      st       <= ST_FILL;
      len_q    <= db_len;
      fill_cnt <= '0;
      adv_cnt  <= '0;
    end else begin
      case (st)
        ST_FILL: if (fill_fire) begin
          fill_cnt <= fill_cnt + 1'b1;
          if (fill_cnt == FILL_W'(N - 1)) st <= ST_RUN;
        end
        ST_RUN: if (adv_fire) begin
          adv_cnt <= adv_cnt + 1'b1;
          if (adv_cnt + 1'b1 == target) st <= ST_DONE;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/sym_window.sv
module sym_window
  import sww_pkg::*;
#(
  parameter int N     = 256,
  parameter int LEN_W = 20
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [LEN_W-1:0]      db_len,
  input  logic                  advance,
  output logic                  adv_ready,
  output logic [2*N-1:0]        win_sym,
  output logic [N-1:0]          win_vld,
  output logic                  done,
  output logic                  mem_rd_en,
  output logic [LEN_W-4:0]      mem_rd_addr,
  input  logic [31:0]           mem_rd_data
);
  localparam int ADDR_W = LEN_W - 3;

  // Internal events brought out by name for the checker.
  logic             start_acc, active, shift_fire, window_live, rd_pend;
  logic             sym_avail, sym_real;
  logic [SYM_W-1:0] sym_next;
  logic [LEN_W-1:0] len_q;

  sww_ctrl #(.N(N), .LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .db_len(db_len),
    .advance(advance), .sym_avail(sym_avail), .start_acc(start_acc),
    .active(active), .shift_fire(shift_fire), .adv_ready(adv_ready),
    .done(done), .window_live(window_live), .len_q(len_q)
  );

  sww_fetch #(.LEN_W(LEN_W), .ADDR_W(ADDR_W)) u_fetch (
    .clk(clk), .rst_n(rst_n), .restart(start_acc), .active(active),
    .shift_req(shift_fire), .len_q(len_q), .mem_rd_data(mem_rd_data),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .sym_out(sym_next),
    .sym_real(sym_real), .sym_avail(sym_avail), .rd_pend(rd_pend)
  );

  sww_shift #(.N(N)) u_shift (
    .clk(clk), .rst_n(rst_n), .clear(start_acc), .shift(shift_fire),
    .sym_in(sym_next), .vld_in(sym_real), .win_sym(win_sym), .win_vld(win_vld)
  );
endmodule

// File: rtl/sym_window_chk.sv
module sym_window_chk #(
  parameter int N = 256
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic           start_acc,
  input logic           adv_ready,
  input logic           done,
  input logic           shift_fire,
  input logic           window_live,
  input logic           rd_pend,
  input logic           mem_rd_en,
  input logic [2*N-1:0] win_sym,
  input logic [N-1:0]   win_vld
);
  AST_SHIFT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    shift_fire && !start_acc |=> win_sym[2*N-3:0] == $past(win_sym[2*N-1:2])); // R4
  AST_VLD_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    shift_fire && !start_acc |=> win_vld[N-2:0] == $past(win_vld[N-1:1])); // R4
  AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !win_vld[N-1] |-> win_sym[2*N-1:2*N-2] == 2'b00); // R5
  AST_VLD_PREFIX: assert property (@(posedge clk) disable iff (!rst_n)
    window_live |-> ((win_vld & (win_vld + 1'b1)) == '0)); // R5
  AST_READY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adv_ready) |-> done); // R6
  AST_ONE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pend |-> !mem_rd_en); // R7
  AST_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(adv_ready && done)); // R8
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done); // R8
  AST_CLEAR_START: assert property (@(posedge clk) disable iff (!rst_n)
    start_acc |=> win_vld == '0); // R3
endmodule

bind sym_window sym_window_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .start_acc(start_acc),
  .adv_ready(adv_ready), .done(done), .shift_fire(shift_fire),
  .window_live(window_live), .rd_pend(rd_pend), .mem_rd_en(mem_rd_en),
  .win_sym(win_sym), .win_vld(win_vld)
);

// File: tb/tb_sym_window.sv
module tb_sym_window;
  localparam int N     = 8;
  localparam int LEN_W = 10;
  localparam int AW    = LEN_W - 3;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start = 1'b0;
  logic [LEN_W-1:0] db_len = '0;
  logic            advance = 1'b0;
  logic            adv_ready, done, mem_rd_en;
  logic [2*N-1:0]  win_sym;
  logic [N-1:0]    win_vld;
  logic [AW-1:0]   mem_rd_addr;
  logic [31:0]     mem_rd_data = '0;
  logic [31:0]     mem [0:127];

  int checks = 0;
  int errors = 0;
  int rd_count = 0;
  int rd_bad = 0;
  int rd_base = 0;

  always #2 clk = ~clk;

  sym_window #(.N(N), .LEN_W(LEN_W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .db_len(db_len),
    .advance(advance), .adv_ready(adv_ready), .win_sym(win_sym),
    .win_vld(win_vld), .done(done), .mem_rd_en(mem_rd_en),
    .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data)
  );

  always @(posedge clk) begin
    if (mem_rd_en) begin
      mem_rd_data <= mem[mem_rd_addr];
      if (int'(mem_rd_addr) != rd_count - rd_base) rd_bad++;
      rd_count++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  // Database symbol j: word j/16, bits [2(j%16)+1 : 2(j%16)].
  function automatic logic [1:0] db_sym(input int j, input int len);
    logic [31:0] w;
    if (j >= len) return 2'b00;
    w = mem[j / 16];
    return w[2*(j % 16) +: 2];
  endfunction

  task automatic check_window(input int k, input int len, input string req);
    logic [2*N-1:0] es;
    logic [N-1:0]   ev;
    for (int i = 0; i < N; i++) begin
      es[2*i +: 2] = db_sym(k + i, len);
      ev[i]        = (k + i < len);
    end
    chk(win_sym == es, req, "window symbols", 64'(win_sym), 64'(es));
    chk(win_vld == ev, req, "window valid", 64'(win_vld), 64'(ev));
  endtask

  task automatic load_mem(input int seed);
    logic [31:0] s;
    s = 32'(seed) * 32'h9E3779B9 + 32'd7;
    for (int a = 0; a < 128; a++) begin
      s = s * 32'd1103515245 + 32'd12345;
      mem[a] = s ^ {s[15:0], s[31:16]};
    end
  endtask

  task automatic test_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(win_vld == '0 && win_sym == '0, "R1", "window in reset", 64'(win_sym), 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!done && !adv_ready && !mem_rd_en, "R1", "control after reset",
        {61'h0, done, adv_ready, mem_rd_en}, 64'h0);
    chk(win_vld == '0, "R1", "valid after reset", 64'(win_vld), 64'h0);
  endtask

  // One sweep: len symbols; gaps inserts idle cycles; hold_fill keeps advance
  // high during the fill; poke pulses start mid-sweep.
  task automatic test_sweep(input int len, input int seed, input bit gaps,
                            input bit hold_fill, input bit poke);
    int k;
    int wait_n;
    int target;
    int words;
    load_mem(seed);
    rd_base = rd_count;
    rd_bad  = 0;
    db_len  = LEN_W'(len);
    start   = 1'b1;
    advance = hold_fill;
    @(negedge clk);
    start = 1'b0;
    wait_n = 0;
    while (!adv_ready && wait_n < 400) begin
      @(negedge clk);
      wait_n++;
    end
    chk(adv_ready, "R3", "ready after fill", 64'(adv_ready), 64'h1);
    check_window(0, len, hold_fill ? "R9" : "R3");
    target = len + N - 1;
    k = 0;
    while (k < target) begin
      if (gaps && (k % 3 == 1)) begin
        advance = 1'b0;
        @(negedge clk);
        check_window(k, len, "R9");
      end
      chk(adv_ready && !done, "R6", "ready held", {62'h0, adv_ready, done}, 64'h2);
      advance = 1'b1;
      start   = poke && (k == 2);
      @(negedge clk);
      start = 1'b0;
      k++;
      if (k < target) check_window(k, len, (poke && k == 3) ? "R10" : (k + N > len) ? "R5" : "R4");
    end
    advance = 1'b0;
    chk(done && !adv_ready, "R8", "done after sweep", {62'h0, done, adv_ready}, 64'h2);
    check_window(k, len, "R8");
    advance = 1'b1;
    repeat (3) @(negedge clk);
    advance = 1'b0;
    chk(done, "R8", "done held", 64'(done), 64'h1);
    check_window(k, len, "R9");
    words = (len + 15) / 16;
    chk(rd_count - rd_base == words, "R7", "read count", 64'(rd_count - rd_base), 64'(words));
    chk(rd_bad == 0, "R7", "read address order", 64'(rd_bad), 64'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R6 watchdog expired act=%0d exp=%0d", 100000, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    test_reset();
    test_sweep(37, 1, 1'b0, 1'b0, 1'b0);  // R2 R4 R5 R7: mid-word end, back to back
    test_sweep(5, 2, 1'b1, 1'b1, 1'b0);   // R11 R9: short database, gapped advances
    test_sweep(32, 3, 1'b0, 1'b0, 1'b1);  // R10: start ignored mid-sweep, word-aligned end
    test_sweep(0, 4, 1'b1, 1'b0, 1'b0);   // R5: empty database, all padding
    test_sweep(50, 5, 1'b1, 1'b1, 1'b0);  // R6: longer sweep with gaps
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule